// File: doc/BRIEF.md
# Dual-Channel Reload Timer

The block is a timer peripheral with two independent 16-bit channels, reached over a byte-wide register bus with plain read and write strobes that act in a single cycle. Each channel keeps a down counter and a reload value. One free-running prescaler, common to both channels, produces a count step once every twenty system clocks. An enabled counter moves down by one on each step. A counter that sits at zero takes its reload value on the next step instead of decrementing.

When a counter steps from one to zero, its channel flag is set. The channel drives its interrupt line while both the flag and the channel's interrupt enable are set. Software clears a flag with a two-read handshake. It first reads the control byte, which arms the clear for every channel. It then reads either byte of that channel's counter. With counting stopped, software may write and read the counter bytes freely. The reload bytes can be written at any time.

Top module: `dual_reload_timer`

## Requirements
- R1: Byte address map: ch0 counter low/high at 0/1, ch0 reload low/high at 2/3, control at 4, ch1 counter low/high at 5/6, ch1 reload low/high at 7/8. The 16-bit counter borrows correctly across its byte boundary.
- R2: The prescaler resets to 0 and counts 0..19 without stopping. An enabled counter changes only on the clock edge where the prescaler reads 19, so it steps once every 20 clocks.
- R3: An enabled counter at 0 loads its reload value on the next step. Otherwise it decrements by one.
- R4: When an enabled counter steps from 1 to 0, its flag (control bit 4 for ch0, bit 5 for ch1) becomes 1.
- R5: irq_o[c] is 1 exactly while flag c and interrupt enable c (control bit 2 for ch0, bit 3 for ch1) are both 1.
- R6: A read of the control byte arms every channel, whether or not its flag is set. A later read of either counter byte of an armed channel clears that channel's flag. A counter-byte read always disarms its own channel. A counter-byte read without arming leaves the flag at 1.
- R7: While count enable c (control bit 0 for ch0, bit 1 for ch1) is 0, the counter holds its value and both of its bytes can be written and read. While the enable is 1, counter writes are ignored.
- R8: Reload bytes are written separately and read back as written.
- R9: After reset, every counter and reload register reads 0xFFFF and the control byte reads 0x00.
- R10: If a step to zero and a clearing counter read land in the same cycle, the flag ends at 1.
- R11: Control writes update only bits [3:0]. The flag bits and bits [7:6] read back as set by the hardware, and bits [7:6] always read 0. Unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte address |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Per-channel interrupt request |

## Verification
The assertions assume that wr_i and rd_i are never high in the same cycle, and that a read happens only when the address is stable for that whole cycle. Every bus access in the bench drives exactly one strobe for one cycle, with the address held from the falling edge through the next rising edge. The flag-clear checks also rely on a counter read being the only way a flag can fall. For that reason the bench issues counter reads only through its bus task, so every falling flag has a matching read in the cycle before it.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned DW        = 8;
  localparam int unsigned CNT_W     = 2 * DW;
  localparam int unsigned AW        = 4;
  localparam int unsigned PRESCALE  = 20;
  localparam int unsigned CH_STRIDE = 5;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(4);

  typedef enum logic [1:0] {
    OFS_CNT_LO = 2'd0,
    OFS_CNT_HI = 2'd1,
    OFS_RLD_LO = 2'd2,
    OFS_RLD_HI = 2'd3
  } ch_ofs_e;

  function automatic logic [AW-1:0] ch_base(input int unsigned c);
    return AW'(c * CH_STRIDE);
  endfunction
endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
  parameter int unsigned DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/prt_channel.sv
module prt_channel #(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            en_i,
  input  logic [3:0]      wr_sel_i,   // cnt lo, cnt hi, rld lo, rld hi
  input  logic [DW-1:0]   wdata_i,
  input  logic            ctrl_rd_i,
  input  logic            cnt_rd_i,
  output logic [2*DW-1:0] cnt_o,
  output logic [2*DW-1:0] rld_o,
  output logic            flag_o
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] cnt_q, rld_q;
  logic          flag_q, armed_q;
  logic          step, hit;

  assign step = en_i && tick_i;
  assign hit  = step && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (en_i) begin
      if (tick_i) cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - CW'(1);
    end else begin
      if (wr_sel_i[0]) cnt_q[DW-1:0]  <= wdata_i;
      if (wr_sel_i[1]) cnt_q[CW-1:DW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '1;
    end else begin
      if (wr_sel_i[2]) rld_q[DW-1:0]  <= wdata_i;
      if (wr_sel_i[3]) rld_q[CW-1:DW] <= wdata_i;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (hit) flag_q <= 1'b1;
      else if (cnt_rd_i && armed_q) flag_q <= 1'b0;
      if (ctrl_rd_i) armed_q <= 1'b1;
      else if (cnt_rd_i) armed_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/prt_rdmux.sv
module prt_rdmux
  import prt_pkg::*;
(
  input  logic [AW-1:0]                 addr_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  rld_i,
  input  logic [DW-1:0]                 ctrl_i,
  output logic [DW-1:0]                 rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = ctrl_i;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (addr_i == ch_base(c) + AW'(OFS_CNT_LO)) rdata_o = cnt_i[c][DW-1:0];
      if (addr_i == ch_base(c) + AW'(OFS_CNT_HI)) rdata_o = cnt_i[c][CNT_W-1:DW];
      if (addr_i == ch_base(c) + AW'(OFS_RLD_LO)) rdata_o = rld_i[c][DW-1:0];
      if (addr_i == ch_base(c) + AW'(OFS_RLD_HI)) rdata_o = rld_i[c][CNT_W-1:DW];
    end
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import prt_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = PRESCALE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic                        tick;
  logic [NUM_CH-1:0]           en_q, ie_q, flag;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt, rld;
  logic [DW-1:0]               ctrl_byte;
  logic                        ctrl_rd;

  assign ctrl_rd = rd_i && (addr_i == CTRL_ADDR);

  prt_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      ie_q <= '0;
    end else if (wr_i && addr_i == CTRL_ADDR) begin
      en_q <= wdata_i[NUM_CH-1:0];
      ie_q <= wdata_i[2*NUM_CH-1:NUM_CH];
    end
  end

  always_comb begin
    ctrl_byte = '0;
    ctrl_byte[NUM_CH-1:0]          = en_q;
    ctrl_byte[2*NUM_CH-1:NUM_CH]   = ie_q;
    ctrl_byte[3*NUM_CH-1:2*NUM_CH] = flag;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [3:0] wr_sel;
    logic       cnt_rd;

    for (genvar k = 0; k < 4; k++) begin : g_sel
      assign wr_sel[k] = wr_i && (addr_i == ch_base(c) + AW'(k));
    end

    assign cnt_rd = rd_i && ((addr_i == ch_base(c) + AW'(OFS_CNT_LO)) ||
                             (addr_i == ch_base(c) + AW'(OFS_CNT_HI)));

    prt_channel #(.DW(DW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .en_i      (en_q[c]),
      .wr_sel_i  (wr_sel),
      .wdata_i   (wdata_i),
      .ctrl_rd_i (ctrl_rd),
      .cnt_rd_i  (cnt_rd),
      .cnt_o     (cnt[c]),
      .rld_o     (rld[c]),
      .flag_o    (flag[c])
    );
  end

  prt_rdmux u_rdmux (
    .addr_i  (addr_i),
    .cnt_i   (cnt),
    .rld_i   (rld),
    .ctrl_i  (ctrl_byte),
    .rdata_o (rdata_o)
  );

  assign irq_o = flag & ie_q;
endmodule

// File: rtl/prt_checker.sv
module prt_checker
  import prt_pkg::*;
(
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [AW-1:0]                addr_i,
  input logic                         wr_i,
  input logic                         rd_i,
  input logic                         tick_i,
  input logic [NUM_CH-1:0]            en_i,
  input logic [NUM_CH-1:0]            flag_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] rld_i
);
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [AW-1:0] LO = ch_base(c);
    localparam logic [AW-1:0] HI = ch_base(c) + AW'(1);

    assert_no_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] && !tick_i) |=> $stable(cnt_i[c]));

    assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] && tick_i && cnt_i[c] != '0) |=> (cnt_i[c] == $past(cnt_i[c]) - CNT_W'(1)));

    assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] && tick_i && cnt_i[c] == '0) |=> (cnt_i[c] == $past(rld_i[c])));

    assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] && tick_i && cnt_i[c] == CNT_W'(1)) |=> flag_i[c]);

    assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_i[c]) |-> $past(rd_i && (addr_i == LO || addr_i == HI)));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[c] && !(wr_i && (addr_i == LO || addr_i == HI))) |=> $stable(cnt_i[c]));
  end
endmodule

bind dual_reload_timer prt_checker u_prt_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .tick_i (tick),
  .en_i   (en_q),
  .flag_i (flag),
  .cnt_i  (cnt),
  .rld_i  (rld)
);

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] irq_o;

  int vectors = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;   // 50 MHz

  dual_reload_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // behavioural reference
  int m_cnt[2] = '{65535, 65535};
  int m_rld[2] = '{65535, 65535};
  bit m_flag[2], m_arm[2], m_en[2], m_ie[2];
  int m_presc = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 65535; m_rld[c] = 65535;
        m_flag[c] = 0; m_arm[c] = 0; m_en[c] = 0; m_ie[c] = 0;
      end
      m_presc = 0;
    end else begin
      bit tk, crd;
      tk = (m_presc == 19);
      m_presc = tk ? 0 : m_presc + 1;
      crd = rd_i && addr_i == 4;
      for (int c = 0; c < 2; c++) begin
        int b;
        bit nrd, hit;
        b = c * 5;
        nrd = rd_i && (addr_i == b || addr_i == b + 1);
        hit = m_en[c] && tk && m_cnt[c] == 1;
        if (hit) m_flag[c] = 1;
        else if (nrd && m_arm[c]) m_flag[c] = 0;
        if (crd) m_arm[c] = 1;
        else if (nrd) m_arm[c] = 0;
        if (m_en[c]) begin
          if (tk) m_cnt[c] = (m_cnt[c] == 0) ? m_rld[c] : m_cnt[c] - 1;
        end else begin
          if (wr_i && addr_i == b)     m_cnt[c] = (m_cnt[c] & 'hFF00) | wdata_i;
          if (wr_i && addr_i == b + 1) m_cnt[c] = (m_cnt[c] & 'h00FF) | (int'(wdata_i) << 8);
        end
        if (wr_i && addr_i == b + 2) m_rld[c] = (m_rld[c] & 'hFF00) | wdata_i;
        if (wr_i && addr_i == b + 3) m_rld[c] = (m_rld[c] & 'h00FF) | (int'(wdata_i) << 8);
      end
      if (wr_i && addr_i == 4) begin
        m_en[0] = wdata_i[0]; m_en[1] = wdata_i[1];
        m_ie[0] = wdata_i[2]; m_ie[1] = wdata_i[3];
      end
    end
  end

  function automatic int exp_rd(input int a);
    if (a == 4) return (int'(m_flag[1]) << 5) | (int'(m_flag[0]) << 4) | (int'(m_ie[1]) << 3) |
                       (int'(m_ie[0]) << 2) | (int'(m_en[1]) << 1) | int'(m_en[0]);
    for (int c = 0; c < 2; c++) begin
      if (a == c * 5)     return m_cnt[c] & 255;
      if (a == c * 5 + 1) return m_cnt[c] >> 8;
      if (a == c * 5 + 2) return m_rld[c] & 255;
      if (a == c * 5 + 3) return m_rld[c] >> 8;
    end
    return 0;
  endfunction

  task automatic chk(input logic [15:0] got, input int exp, input string tag);
    vectors++;
    if (got !== 16'(exp)) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int a, input bit w, input bit r, input int d, input string tag);
    @(negedge clk_i);
    addr_i = 4'(a); wr_i = w; rd_i = r; wdata_i = 8'(d);
    #1;
    if (r) chk(16'(rdata_o), exp_rd(a), tag);
    chk(16'(irq_o), (int'(m_flag[1] & m_ie[1]) << 1) | int'(m_flag[0] & m_ie[0]), "R5 irq");
  endtask

  task automatic rd_const(input int a, input int e, input string tag);
    cyc(a, 0, 1, 0, tag);
    chk(16'(rdata_o), e, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, "idle");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset values
    rd_const(4, 'h00, "R9 ctrl");
    rd_const(0, 'hFF, "R9 cnt0 lo");
    rd_const(1, 'hFF, "R9 cnt0 hi");
    rd_const(7, 'hFF, "R9 rld1 lo");
    rd_const(8, 'hFF, "R9 rld1 hi");
    // R7 writes while stopped, R8 reload bytes
    cyc(0, 1, 0, 'h03, "R7"); cyc(1, 1, 0, 'h00, "R7");
    rd_const(0, 'h03, "R7 cnt0 lo");
    rd_const(1, 'h00, "R7 cnt0 hi");
    cyc(3, 1, 0, 'h00, "R8"); cyc(2, 1, 0, 'h03, "R8");
    rd_const(2, 'h03, "R8 rld0 lo");
    rd_const(3, 'h00, "R8 rld0 hi");
    // R11 unmapped and read-only bits
    cyc(15, 1, 0, 'hAA, "R11");
    rd_const(15, 'h00, "R11 unmapped");
    cyc(4, 1, 0, 'hF5, "R11");
    rd_const(4, 'h05, "R11 ctrl");
    // R7 write ignored while enabled
    cyc(0, 1, 0, 'h77, "R7");
    cyc(0, 0, 1, 0, "R7 ignored write");
    // R2 R3 R4 run to zero
    idle(90);
    cyc(4, 1, 0, 'h04, "R4");             // stop ch0, keep ie0
    chk(16'(irq_o[0]), 1, "R4 flag irq");
    // R6 counter read without arming keeps flag; reads with arming clear
    cyc(4, 0, 1, 0, "R6 arm");
    cyc(2, 0, 1, 0, "R6 non-counter read");
    cyc(1, 0, 1, 0, "R6 clear");
    cyc(0, 0, 0, 0, "R6");
    chk(16'(irq_o[0]), 0, "R6 flag cleared");
    // flag without arming stays: re-trigger
    cyc(0, 1, 0, 'h01, "R6"); cyc(1, 1, 0, 'h00, "R6");
    cyc(4, 1, 0, 'h05, "R6");
    idle(25);
    cyc(0, 0, 1, 0, "R6 unarmed read");
    cyc(1, 0, 1, 0, "R6 unarmed read");
    chk(16'(irq_o[0]), 1, "R6 flag kept");
    // R1 borrow across bytes, channel 1
    cyc(4, 1, 0, 'h00, "R1");
    cyc(5, 1, 0, 'h00, "R1"); cyc(6, 1, 0, 'h01, "R1");
    cyc(4, 1, 0, 'h02, "R1");
    idle(25);
    cyc(4, 1, 0, 'h00, "R1");
    rd_const(5, 'hFF, "R1 borrow lo");
    rd_const(6, 'h00, "R1 borrow hi");
    // R10 set vs clear races on ch1
    cyc(7, 1, 0, 'h02, "R10"); cyc(8, 1, 0, 'h00, "R10");
    cyc(5, 1, 0, 'h01, "R10"); cyc(6, 1, 0, 'h00, "R10");
    cyc(4, 1, 0, 'h0B, "R10");
    for (int i = 0; i < 300; i++) begin
      cyc(4, 0, 1, 0, "R10 ctrl");
      cyc(5 + (i % 2), 0, 1, 0, "R10 cnt read");
    end
    idle(200);
    rd_const(4, exp_rd(4), "R4 ctrl final");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule